// File: doc/BRIEF.md
# Mode-Configurable Word Serializer with Loopback Paths

This block turns a parallel word of up to eight bits into one serial bit stream. It is modelled at the serial bit rate: one clock edge launches one serial bit. A line-group select and a two-bit ratio select set how many lanes of the word are sent per word period: two, four or eight. Lane 0 always leaves first. A two-bit phase select moves the point within the word period at which the parallel word is sampled. A word-rate tick marks the cycle that carries lane 0, so the producer can align its writes.

There are two test paths. A line loopback input can replace the serialized parallel data on the serial output. A system loopback output pair copies the serial stream when enabled and otherwise sits at a fixed quiet level. One ratio setting is not allowed in the lower line group. If it is selected anyway, the parallel path sends constant zero.

Top module: `modal_serializer`

## Requirements
- R1: While reset is low: serData is 0, wordTick is 1, and with sysLbN high the loopback pair reads sysLbOutP=0, sysLbOutN=1.
- R2: The word length N follows modeSel: 2'b00 gives 2, 2'b10 gives 4, 2'b01 and 2'b11 give 8. wordTick is high once every N cycles.
- R3: Lane k of a captured word is on serData exactly k cycles after the cycle in which wordTick is high (lane 0 in the wordTick cycle).
- R4: Lanes at or above N are ignored. Their values never reach serData.
- R5: Number the wordTick cycle 0. The word is sampled at the clock edge that ends cycle (phaseSel*N)/4, rounded down. It is sent in the following word period.
- R6: With groupSdh low and modeSel 2'b11 (not allowed), serData stays 0 on the parallel path.
- R7: A change of modeSel or groupSdh takes effect only at the next word boundary. The word in progress completes at its old length.
- R8: serClk toggles every cycle and is low in every cycle in which wordTick is high.
- R9: While lineLbN is low, serData equals the lineLbIn value of the previous cycle.
- R10: While sysLbN is low, sysLbOutP equals serData and sysLbOutN equals its inverse. While sysLbN is high, they are 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Synchronous reset, active low; loads the mode |
| groupSdh | input | 1 | Line group: 1 higher-rate group, 0 lower-rate group |
| modeSel | input | 2 | Ratio select |
| phaseSel | input | 2 | Capture point within the word, in quarter steps |
| parData | input | 8 | Parallel word, lane 0 sent first |
| lineLbN | input | 1 | Line loopback enable, active low |
| lineLbIn | input | 1 | Serial data returned for line loopback |
| sysLbN | input | 1 | System loopback enable, active low |
| serData | output | 1 | Serial data |
| serClk | output | 1 | Serial clock, one toggle per bit |
| wordTick | output | 1 | High in the cycle that carries lane 0 |
| sysLbOutP | output | 1 | System loopback true output |
| sysLbOutN | output | 1 | System loopback complement output |

## Verification
A sampled word appears on serData one full word period after the edge that sampled it. Lane k then follows the wordTick cycle by k cycles. For this reason the bench waits several ticks after every configuration change and reads each word starting from a tick. The phase cases change parData in the cycle that ends with the sampling edge, and again one cycle later, and then look at the word after the next tick. Line loopback has one register of delay, so it is compared one cycle after each drive. serClk, the system loopback pair and the invalid-mode output are combinational from registers, so they are checked in the same cycle. All sampling is done on falling clock edges.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // strobes from sequencing control to the datapath
  typedef struct packed {
    logic capture;  // sample the parallel word at this edge
    logic load;     // last bit of word: move word into shifter
    logic first;    // lane 0 is on the serial output
    logic invalid;  // disallowed group/ratio combination
  } serStrobe_t;
endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import ser_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              groupSdh,
  input  logic [1:0]        modeSel,
  input  logic [1:0]        phaseSel,
  output serStrobe_t        strobe,
  output logic [WORD_W-1:0] laneMask
);
  logic [2:0]       modeReg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   curN;
  logic [CNT_W:0]   lastIdx;
  logic [CNT_W+2:0] capProd;
  logic [CNT_W:0]   capIdx;

  always_comb begin
    case (modeReg[1:0])
      2'b00:   curN = (CNT_W+1)'(2);
      2'b10:   curN = (CNT_W+1)'(WORD_W / 2);
      default: curN = (CNT_W+1)'(WORD_W);
    endcase
  end

  assign lastIdx = curN - 1'b1;
  assign capProd = {{(CNT_W+1){1'b0}}, phaseSel} * {2'b00, curN};
  assign capIdx  = capProd[CNT_W+2:2];

  genvar gi;
  generate
    for (gi = 0; gi < WORD_W; gi++) begin : g_mask
      assign laneMask[gi] = (gi < int'(curN));
    end
  endgenerate

  assign strobe.capture = ({1'b0, cnt} == capIdx);
  assign strobe.load    = ({1'b0, cnt} == lastIdx);
  assign strobe.first   = (cnt == '0);
  assign strobe.invalid = (modeReg == 3'b011);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      modeReg <= {groupSdh, modeSel};
    end else if (strobe.load) begin
      cnt     <= '0;
      modeReg <= {groupSdh, modeSel};
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: counter stays inside the current word
  a_r2_cnt_in_word: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, cnt} < curN);
  // R2: the last bit is followed by lane 0
  a_r2_wrap_to_first: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> strobe.first);
  // R7: mode only changes at a word boundary
  a_r7_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(modeReg));
endmodule

// File: rtl/ser_datapath.sv
module ser_datapath
  import ser_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  serStrobe_t        strobe,
  input  logic [WORD_W-1:0] laneMask,
  input  logic [WORD_W-1:0] parData,
  input  logic              lineLbN,
  input  logic              lineLbIn,
  input  logic              sysLbN,
  output logic              serData,
  output logic              serClk,
  output logic              sysLbOutP,
  output logic              sysLbOutN
);
  logic [WORD_W-1:0] holdReg;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] masked;
  logic              lbReg;
  logic              clkReg;

  assign masked = parData & laneMask;

  always_ff @(posedge clk) begin
    lbReg <= lineLbIn;
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '0;
      clkReg   <= 1'b0;
    end else begin
      if (strobe.capture) holdReg <= masked;
      if (strobe.load) shiftReg <= strobe.capture ? masked : holdReg;
      else             shiftReg <= shiftReg >> 1;
      clkReg <= strobe.load ? 1'b0 : ~clkReg;
    end
  end

  assign serClk    = clkReg;
  assign serData   = !lineLbN ? lbReg : (strobe.invalid ? 1'b0 : shiftReg[0]);
  assign sysLbOutP = !sysLbN & serData;
  assign sysLbOutN = sysLbN | ~serData;

  // R3: a loaded word starts on the shifter unchanged
  a_r3_load_word: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && !strobe.capture |=> shiftReg == $past(holdReg));
  // R8: serial clock alternates each bit
  a_r8_clk_toggle: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> serClk != $past(serClk));
  // R8: serial clock is low on lane 0
  a_r8_clk_low_first: assert property (@(posedge clk) disable iff (!rstN)
    strobe.first |-> !serClk);
  // R9: line loopback carries the previous-cycle input
  a_r9_line_loop: assert property (@(posedge clk) disable iff (!rstN)
    !lineLbN |-> serData == $past(lineLbIn));
endmodule

// File: rtl/modal_serializer.sv
module modal_serializer
  import ser_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              groupSdh,
  input  logic [1:0]        modeSel,
  input  logic [1:0]        phaseSel,
  input  logic [WORD_W-1:0] parData,
  input  logic              lineLbN,
  input  logic              lineLbIn,
  input  logic              sysLbN,
  output logic              serData,
  output logic              serClk,
  output logic              wordTick,
  output logic              sysLbOutP,
  output logic              sysLbOutN
);
  serStrobe_t        strobe;
  logic [WORD_W-1:0] laneMask;

  ser_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .groupSdh(groupSdh), .modeSel(modeSel),
    .phaseSel(phaseSel), .strobe(strobe), .laneMask(laneMask)
  );

  ser_datapath #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .laneMask(laneMask),
    .parData(parData), .lineLbN(lineLbN), .lineLbIn(lineLbIn),
    .sysLbN(sysLbN), .serData(serData), .serClk(serClk),
    .sysLbOutP(sysLbOutP), .sysLbOutN(sysLbOutN)
  );

  assign wordTick = strobe.first;
endmodule

// File: tb/modal_serializer_tb.sv
module modal_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       groupSdh = 1'b1;
  logic [1:0] modeSel = 2'b11;
  logic [1:0] phaseSel = 2'b00;
  logic [7:0] parData = 8'h00;
  logic       lineLbN = 1'b1;
  logic       lineLbIn = 1'b0;
  logic       sysLbN = 1'b1;
  logic       serData, serClk, wordTick, sysLbOutP, sysLbOutN;

  int  applied = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  modal_serializer dut_i (
    .clk(clk), .rstN(rstN), .groupSdh(groupSdh), .modeSel(modeSel),
    .phaseSel(phaseSel), .parData(parData), .lineLbN(lineLbN),
    .lineLbIn(lineLbIn), .sysLbN(sysLbN), .serData(serData),
    .serClk(serClk), .wordTick(wordTick), .sysLbOutP(sysLbOutP),
    .sysLbOutN(sysLbOutN)
  );

  // {groupSdh, modeSel, parData}; phase 0
  localparam logic [10:0] VECS [7] = '{
    {1'b1, 2'b00, 8'hFD}, {1'b0, 2'b00, 8'h02}, {1'b1, 2'b10, 8'hA6},
    {1'b0, 2'b10, 8'h39}, {1'b1, 2'b01, 8'hC5}, {1'b1, 2'b11, 8'h3C},
    {1'b0, 2'b01, 8'h96}
  };

  function automatic int wordLen(input logic [1:0] m);
    case (m)
      2'b00:   return 2;
      2'b10:   return 4;
      default: return 8;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // advance to next falling edge where wordTick is high; returns cycles taken
  task automatic waitTick(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!wordTick && cyc < 64);
  endtask

  // called at a tick falling edge; collects n lanes
  task automatic readWord(input int n, output logic [7:0] w);
    w = '0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      w[k] = serData;
    end
  endtask

  task automatic phaseCase(input logic [1:0] p, input int t, input bit expectNew);
    int c;
    logic [7:0] w;
    groupSdh = 1'b1; modeSel = 2'b11; phaseSel = p; parData = 8'h5A;
    doReset();
    repeat (3) waitTick(c);
    for (int k = 0; k < t; k++) @(negedge clk);
    parData = 8'hC3;
    waitTick(c);
    readWord(8, w);
    check(w == (expectNew ? 8'hC3 : 8'h5A), "R5 phase capture point", w,
          expectNew ? 8'hC3 : 8'h5A);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    int c, c2;
    logic [7:0] w;
    bit ok;

    // R1: reset state
    repeat (2) @(negedge clk);
    check(serData == 1'b0 && wordTick == 1'b1, "R1 reset outputs",
          {serData, wordTick}, 2'b01);
    check(sysLbOutP == 1'b0 && sysLbOutN == 1'b1, "R1 reset loopback pair",
          {sysLbOutP, sysLbOutN}, 2'b01);

    // vector table: R2 length, R3 lane order, R4 unused lanes
    foreach (VECS[i]) begin
      int n;
      logic [7:0] expW;
      groupSdh = VECS[i][10];
      modeSel  = VECS[i][9:8];
      parData  = VECS[i][7:0];
      n = wordLen(VECS[i][9:8]);
      expW = VECS[i][7:0] & 8'((1 << n) - 1);
      doReset();
      repeat (3) waitTick(c);
      readWord(n, w);
      check(w == expW, "R3 R4 serial lanes", w, expW);
      waitTick(c);
      waitTick(c2);
      check(c2 == n, "R2 tick spacing", c2, n);
    end

    // R5: phase 1 samples at end of cycle 2, phase 3 at end of cycle 6
    phaseCase(2'd1, 2, 1'b1);
    phaseCase(2'd1, 3, 1'b0);
    phaseCase(2'd3, 6, 1'b1);
    phaseCase(2'd3, 7, 1'b0);

    // R6: disallowed combination sends zero
    groupSdh = 1'b0; modeSel = 2'b11; phaseSel = 2'b00; parData = 8'hFF;
    doReset();
    ok = 1'b1;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (serData !== 1'b0) ok = 1'b0;
    end
    check(ok, "R6 invalid mode output", serData, 0);

    // R8: serial clock
    groupSdh = 1'b1; modeSel = 2'b10; parData = 8'h0F;
    doReset();
    waitTick(c);
    ok = 1'b1;
    for (int k = 0; k < 16; k++) begin
      logic prev;
      prev = serClk;
      if (wordTick && serClk) ok = 1'b0;
      @(negedge clk);
      if (serClk == prev) ok = 1'b0;
    end
    check(ok, "R8 serial clock toggle and phase", serClk, 0);

    // R7: ratio change completes the running word first
    modeSel = 2'b11;
    doReset();
    repeat (2) waitTick(c);
    modeSel = 2'b10;
    waitTick(c);
    check(c == 8, "R7 old word completes", c, 8);
    waitTick(c);
    check(c == 4, "R7 new length after boundary", c, 4);

    // R9 and R10: line loopback drives serData, system pair follows it
    lineLbN = 1'b0;
    for (int k = 0; k < 8; k++) begin
      logic b;
      b = 1'(8'hB2 >> k);
      lineLbIn = b;
      @(negedge clk);
      check(serData == b, "R9 line loopback", serData, b);
      sysLbN = 1'b0;
      #1;
      check(sysLbOutP == b && sysLbOutN == !b, "R10 loopback enabled",
            {sysLbOutP, sysLbOutN}, {b, !b});
      sysLbN = 1'b1;
      #1;
      check(sysLbOutP == 1'b0 && sysLbOutN == 1'b1, "R10 loopback quiet",
            {sysLbOutP, sysLbOutN}, 2'b01);
    end
    lineLbN = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule